// File: doc/BRIEF.md
# Low-Power Deterministic Test Decompressor

This block drives a set of scan chains with deterministic, low-activity test data. A pseudo-random state register runs during each scan load, and a few tester channels are folded into it on every shift cycle, so the tester keeps reseeding it. A phase shifter spreads the register's bits across the chains. Each chain has a holding flop in front of it. In a toggle phase the flop loads new data, but only for chains that the per-pattern chain mask enables. In a hold phase every chain repeats its last bit. Nothing is weighted by probability: chain activity depends only on the per-pattern words and the tester data.

A 4-bit down counter and a phase flip-flop set how long each phase lasts. A start strobe loads the first phase and its length (an offset), the toggle and hold lengths, the chain mask and the number of shift cycles in the pattern. The counter then alternates between toggle and hold phases until the pattern ends. Computing the seed stream is left to the tester side.

Top module: `lp_test_decomp`

## Requirements
- R1: After synchronous reset, chain_o is all zeros, and valid_o, busy_o and phase_o are 0.
- R2: A start strobe sets phase_o to init_mode_i (1 = toggle, 0 = hold) on the next cycle. That first phase lasts offset_i + 1 shift cycles.
- R3: When the phase counter expires on a shift cycle, phase_o inverts. The new phase lasts len + 1 shift cycles, where len is tog_len_i for a toggle phase and hold_len_i for a hold phase, both as captured at start.
- R4: On a shift cycle in a toggle phase, chain j loads s[j] XOR s[15-j], where s is the 16-bit generator state before the shift. This happens only when bit j of the captured chain mask is 1; chains whose mask bit is 0 keep their value.
- R5: On a shift cycle in a hold phase, no chain output changes.
- R6: On each shift cycle the generator state s becomes (s >> 1) XOR (s[0] ? 16'hB400 : 0). Tester channel c is then XORed into bit 15 - 8c. The state starts at 16'h0001 after reset. When no pattern is shifting, the state and chain_o ignore tester_i.
- R7: A start with scan_len_i = N gives exactly N shift cycles. busy_o is high during those cycles. valid_o is high on the cycle after each shift cycle and low otherwise. N = 0 starts nothing.
- R8: A start strobe while busy_o is high restarts the pattern with the new settings. No shift takes place in the cycle of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pattern start strobe, captures all settings |
| init_mode_i | input | 1 | First phase of the pattern, 1 = toggle |
| offset_i | input | 4 | Length of the first phase minus one |
| tog_len_i | input | 4 | Toggle phase length minus one |
| hold_len_i | input | 4 | Hold phase length minus one |
| chain_mask_i | input | N_CHAINS | Chains allowed to load new data in toggle phases |
| scan_len_i | input | LEN_W | Shift cycles in the pattern |
| tester_i | input | N_CH | Tester channel bits injected per shift cycle |
| chain_o | output | N_CHAINS | Scan chain data |
| valid_o | output | 1 | chain_o carries the bit of the previous shift cycle |
| phase_o | output | 1 | Current phase, 1 = toggle |
| busy_o | output | 1 | Pattern shifting in progress |

## Verification
The hardest situations to reach from the ports are the ones where a phase boundary falls on the last shift of a pattern or on a restart. In those cases the counter, the phase flop and the pattern length all change on the same edge. The bench sweeps every combination of first phase, offsets 0 to 3, and short toggle and hold lengths over patterns long enough to cross several boundaries. It also runs the maximum counter values, restarts a pattern partway through and on back-to-back starts, and feeds changing tester bits while idle. Every cycle is compared against an arithmetic model.

// File: rtl/lptd_pkg.sv
package lptd_pkg;

    localparam int LFSR_W = 16;
    localparam int CNT_W  = 4;
    localparam logic [LFSR_W-1:0] LFSR_POLY = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'h0001;

    typedef enum logic {
        PH_HOLD   = 1'b0,
        PH_TOGGLE = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e             init_mode;
        logic [CNT_W-1:0]   offset;
        logic [CNT_W-1:0]   tog_len;
        logic [CNT_W-1:0]   hold_len;
    } pat_cfg_t;

    // Galois shift of the state register.
    function automatic logic [LFSR_W-1:0] lfsr_shift(input logic [LFSR_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_POLY : '0);
    endfunction

    // State bit that receives tester channel c.
    function automatic int inject_pos(input int c, input int n_ch);
        return LFSR_W - 1 - ((c * (LFSR_W / n_ch)) % LFSR_W);
    endfunction

    function automatic phase_e other_phase(input phase_e p);
        return (p == PH_TOGGLE) ? PH_HOLD : PH_TOGGLE;
    endfunction

endpackage

// File: rtl/lptd_phase_timer.sv
module lptd_phase_timer
    import lptd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  pat_cfg_t cfg_i,
    input  logic     adv_i,
    output phase_e   phase_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tog_q;
    logic [CNT_W-1:0] hold_q;
    phase_e           phase_q;
    phase_e           next_phase;

    always_comb next_phase = other_phase(phase_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            tog_q   <= '0;
            hold_q  <= '0;
            phase_q <= PH_HOLD;
        end else if (start_i) begin
            tog_q   <= cfg_i.tog_len;
            hold_q  <= cfg_i.hold_len;
            cnt_q   <= cfg_i.offset;
            phase_q <= cfg_i.init_mode;
        end else if (adv_i) begin
            if (cnt_q == '0) begin
                phase_q <= next_phase;
                cnt_q   <= (next_phase == PH_TOGGLE) ? tog_q : hold_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign phase_o = phase_q;

    a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (cnt_q == $past(cfg_i.offset)) && (phase_q == $past(cfg_i.init_mode)));

    a_r3_flip_at_zero: assert property (@(posedge clk) disable iff (rst)
        (adv_i && cnt_q == '0) |=> (phase_q != $past(phase_q)));

    a_r3_reload_new_phase: assert property (@(posedge clk) disable iff (rst)
        (adv_i && cnt_q == '0) |=> (cnt_q == ((phase_q == PH_TOGGLE) ? tog_q : hold_q)));

    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (adv_i && cnt_q != '0) |=> ((cnt_q == $past(cnt_q) - 1'b1) && $stable(phase_q)));

endmodule

// File: rtl/lptd_lfsr.sv
module lptd_lfsr
    import lptd_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic [N_CH-1:0]   tester_i,
    output logic [LFSR_W-1:0] state_o
);

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] inj;
    logic [LFSR_W-1:0] state_d;

    always_comb begin
        inj = '0;
        for (int c = 0; c < N_CH; c++) begin
            inj[inject_pos(c, N_CH)] = inj[inject_pos(c, N_CH)] ^ tester_i[c];
        end
        state_d = lfsr_shift(state_q) ^ inj;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LFSR_SEED;
        end else if (adv_i) begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    a_r6_frozen_when_idle: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(state_q));

endmodule

// File: rtl/lptd_chain_stage.sv
module lptd_chain_stage
    import lptd_pkg::*;
#(
    parameter int N_CHAINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [N_CHAINS-1:0] mask_i,
    input  logic                shift_i,
    input  phase_e              phase_i,
    input  logic [LFSR_W-1:0]   lfsr_i,
    output logic [N_CHAINS-1:0] chain_o
);

    logic [N_CHAINS-1:0] mask_q;
    logic [N_CHAINS-1:0] chain_q;
    logic [N_CHAINS-1:0] spread;
    logic [N_CHAINS-1:0] chain_d;

    for (genvar j = 0; j < N_CHAINS; j++) begin : g_chain
        localparam int TAP_A = j % LFSR_W;
        localparam int TAP_B = (LFSR_W - 1 - j % LFSR_W);
        assign spread[j]  = lfsr_i[TAP_A] ^ lfsr_i[TAP_B];
        // Input mux of the chain flop: fresh data or its own held value.
        assign chain_d[j] = (phase_i == PH_TOGGLE && mask_q[j]) ? spread[j] : chain_q[j];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            chain_q <= '0;
        end else begin
            if (start_i) begin
                mask_q <= mask_i;
            end
            if (shift_i) begin
                chain_q <= chain_d;
            end
        end
    end

    assign chain_o = chain_q;

    a_r5_hold_phase_stable: assert property (@(posedge clk) disable iff (rst)
        (shift_i && phase_i == PH_HOLD) |=> $stable(chain_q));

    a_r4_masked_chains_keep: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (((chain_q ^ $past(chain_q)) & ~mask_q) == '0));

    a_r7_no_shift_no_change: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(chain_q));

endmodule

// File: rtl/lp_test_decomp.sv
module lp_test_decomp
    import lptd_pkg::*;
#(
    parameter int N_CH     = 2,
    parameter int N_CHAINS = 8,
    parameter int LEN_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                init_mode_i,
    input  logic [CNT_W-1:0]    offset_i,
    input  logic [CNT_W-1:0]    tog_len_i,
    input  logic [CNT_W-1:0]    hold_len_i,
    input  logic [N_CHAINS-1:0] chain_mask_i,
    input  logic [LEN_W-1:0]    scan_len_i,
    input  logic [N_CH-1:0]     tester_i,
    output logic [N_CHAINS-1:0] chain_o,
    output logic                valid_o,
    output logic                phase_o,
    output logic                busy_o
);

    pat_cfg_t          cfg;
    logic              busy_q;
    logic              valid_q;
    logic [LEN_W-1:0]  rem_q;
    logic              adv;
    phase_e            phase;
    logic [LFSR_W-1:0] lfsr_state;

    // A start strobe takes priority over shifting in the same cycle.
    assign adv = busy_q & ~start_i;

    always_comb begin
        cfg.init_mode = phase_e'(init_mode_i);
        cfg.offset    = offset_i;
        cfg.tog_len   = tog_len_i;
        cfg.hold_len  = hold_len_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
            rem_q   <= '0;
        end else begin
            valid_q <= adv;
            if (start_i) begin
                rem_q  <= scan_len_i;
                busy_q <= (scan_len_i != '0);
            end else if (adv) begin
                rem_q <= rem_q - 1'b1;
                if (rem_q == LEN_W'(1)) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    lptd_phase_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cfg_i   (cfg),
        .adv_i   (adv),
        .phase_o (phase)
    );

    lptd_lfsr #(.N_CH(N_CH)) u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .adv_i    (adv),
        .tester_i (tester_i),
        .state_o  (lfsr_state)
    );

    lptd_chain_stage #(.N_CHAINS(N_CHAINS)) u_chains (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .mask_i  (chain_mask_i),
        .shift_i (adv),
        .phase_i (phase),
        .lfsr_i  (lfsr_state),
        .chain_o (chain_o)
    );

    assign valid_o = valid_q;
    assign busy_o  = busy_q;
    assign phase_o = phase;

    a_r7_valid_after_shift: assert property (@(posedge clk) disable iff (rst)
        adv |=> valid_o);

    a_r7_last_shift_ends: assert property (@(posedge clk) disable iff (rst)
        (adv && rem_q == LEN_W'(1)) |=> !busy_o);

    a_r7_zero_length_idle: assert property (@(posedge clk) disable iff (rst)
        (start_i && scan_len_i == '0) |=> !busy_o);

    a_r8_restart_loads: assert property (@(posedge clk) disable iff (rst)
        (start_i && scan_len_i != '0) |=> (busy_o && rem_q == $past(scan_len_i)));

endmodule

// File: tb/lp_test_decomp_tb.sv
module lp_test_decomp_tb;

    localparam int CLK_NS   = 10;
    localparam int N_CH     = 2;
    localparam int N_CHAINS = 8;
    localparam int LEN_W    = 8;

    logic clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic                rst;
    logic                start_i;
    logic                init_mode_i;
    logic [3:0]          offset_i;
    logic [3:0]          tog_len_i;
    logic [3:0]          hold_len_i;
    logic [N_CHAINS-1:0] chain_mask_i;
    logic [LEN_W-1:0]    scan_len_i;
    logic [N_CH-1:0]     tester_i;
    logic [N_CHAINS-1:0] chain_o;
    logic                valid_o;
    logic                phase_o;
    logic                busy_o;

    lp_test_decomp #(.N_CH(N_CH), .N_CHAINS(N_CHAINS), .LEN_W(LEN_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .init_mode_i  (init_mode_i),
        .offset_i     (offset_i),
        .tog_len_i    (tog_len_i),
        .hold_len_i   (hold_len_i),
        .chain_mask_i (chain_mask_i),
        .scan_len_i   (scan_len_i),
        .tester_i     (tester_i),
        .chain_o      (chain_o),
        .valid_o      (valid_o),
        .phase_o      (phase_o),
        .busy_o       (busy_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // Stimulus settings
    logic       b_rst, b_start, b_init;
    logic [3:0] b_off, b_tog, b_hold;
    logic [7:0] b_mask, b_len;

    // Arithmetic model
    logic [15:0] m_lfsr;
    logic [7:0]  m_chain, m_mask, m_rem;
    logic [3:0]  m_cnt, m_tog, m_hold;
    logic        m_valid, m_busy, m_mode, m_first;
    bit          r6_focus = 0;
    bit          r8_focus = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lfsr = 16'h0001; m_chain = '0; m_mask = '0; m_rem = '0;
        m_cnt = '0; m_tog = '0; m_hold = '0;
        m_valid = 0; m_busy = 0; m_mode = 0; m_first = 0;
    endtask

    task automatic tick();
        logic [1:0]  tst;
        logic        adv;
        logic [15:0] nl;
        tst = {cyc[2] ^ cyc[5], cyc[0] ^ cyc[3]};
        rst = b_rst; start_i = b_start; init_mode_i = b_init;
        offset_i = b_off; tog_len_i = b_tog; hold_len_i = b_hold;
        chain_mask_i = b_mask; scan_len_i = b_len; tester_i = tst;
        if (b_rst) begin
            model_reset();
        end else begin
            adv = m_busy && !b_start;
            if (adv) begin
                // R4: masked chains in toggle phase take s[j]^s[15-j]
                for (int j = 0; j < 8; j++)
                    if (m_mode && m_mask[j]) m_chain[j] = m_lfsr[j] ^ m_lfsr[15-j];
                // R6: Galois step then tester injection at bits 15 and 7
                nl = m_lfsr >> 1;
                if (m_lfsr[0]) nl = nl ^ 16'hB400;
                nl[15] = nl[15] ^ tst[0];
                nl[7]  = nl[7]  ^ tst[1];
                m_lfsr = nl;
                // R2/R3 phase timing
                if (m_cnt == 0) begin
                    m_mode  = ~m_mode;
                    m_cnt   = m_mode ? m_tog : m_hold;
                    m_first = 0;
                end else begin
                    m_cnt = m_cnt - 1;
                end
                if (m_rem == 1) m_busy = 0;
                m_rem = m_rem - 1;
            end
            if (b_start) begin
                m_tog = b_tog; m_hold = b_hold; m_mask = b_mask;
                m_cnt = b_off; m_mode = b_init; m_first = 1;
                m_rem = b_len; m_busy = (b_len != 0);
            end
            m_valid = adv;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (!b_rst) begin
            check(r8_focus ? "R8" : "R7", "busy_o", 32'(busy_o), 32'(m_busy));
            check(r8_focus ? "R8" : "R7", "valid_o", 32'(valid_o), 32'(m_valid));
            check(m_first ? "R2" : "R3", "phase_o", 32'(phase_o), 32'(m_mode));
            check(r6_focus ? "R6" : (m_mode ? "R4" : "R5"), "chain_o",
                  32'(chain_o), 32'(m_chain));
        end
    endtask

    task automatic run_pat(input logic init, input logic [3:0] off, input logic [3:0] tg,
                           input logic [3:0] hd, input logic [7:0] mask,
                           input logic [7:0] len, input int gap);
        b_start = 1; b_init = init; b_off = off; b_tog = tg; b_hold = hd;
        b_mask = mask; b_len = len;
        tick();
        b_start = 0;
        repeat (int'(len) + gap) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        b_rst = 1; b_start = 0; b_init = 0; b_off = 0; b_tog = 0; b_hold = 0;
        b_mask = 0; b_len = 0;
        model_reset();
        repeat (3) tick();
        // R1: reset state at the ports
        check("R1", "chain_o", 32'(chain_o), 32'h0);
        check("R1", "valid_o", 32'(valid_o), 32'h0);
        check("R1", "busy_o",  32'(busy_o),  32'h0);
        check("R1", "phase_o", 32'(phase_o), 32'h0);
        b_rst = 0;
        repeat (2) tick();

        // R2 R3 R4 R5: sweep first phase, offset and phase lengths
        for (int off = 0; off < 4; off++)
            for (int im = 0; im < 2; im++)
                for (int tg = 0; tg < 4; tg += 2)
                    for (int hd = 1; hd < 4; hd += 2)
                        run_pat(im[0], 4'(off), 4'(tg), 4'(hd),
                                8'(off * 37 + im * 90 + tg * 11 + hd * 3 + 1), 8'd18, 2);

        // R3: counter at its maximum values
        run_pat(1'b1, 4'hF, 4'hF, 4'hF, 8'hFF, 8'd60, 2);
        // R4: all chains masked off never change
        run_pat(1'b1, 4'd0, 4'd7, 4'd0, 8'h00, 8'd20, 2);

        // R6: tester bits while idle are ignored, then a long toggle run
        r6_focus = 1;
        repeat (25) tick();
        run_pat(1'b1, 4'd0, 4'hF, 4'd0, 8'hFF, 8'd40, 1);
        repeat (10) tick();
        r6_focus = 0;

        // R7: zero-length and single-shift patterns
        run_pat(1'b1, 4'd2, 4'd3, 4'd3, 8'hAA, 8'd0, 5);
        run_pat(1'b0, 4'd0, 4'd1, 4'd1, 8'hFF, 8'd1, 3);
        run_pat(1'b1, 4'd0, 4'd0, 4'd0, 8'h5A, 8'd9, 2);

        // R8: restart in mid pattern and back-to-back starts
        r8_focus = 1;
        run_pat(1'b1, 4'd1, 4'd2, 4'd1, 8'hF0, 8'd30, -23);
        run_pat(1'b0, 4'd3, 4'd1, 4'd2, 8'h3C, 8'd12, -12);
        run_pat(1'b1, 4'd0, 4'd1, 4'd0, 8'hFF, 8'd14, 3);
        r8_focus = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule